// File: doc/BRIEF.md
# Configurable Digital Input Conditioner

This block turns a small group of raw digital input pins into clean logical signals for the control logic behind it. Every channel goes through three stages in a fixed order. First, one global polarity bit decides whether a high or a low pin level means a closed contact. Second, a per-channel debounce filter holds the result back until it has stayed stable for a programmed number of millisecond ticks. Third, a per-channel inversion bit can flip the result. With that bit set, a closed contact switches the assigned function off instead of on.

Raw pins first pass through a short synchronizer. An external one-cycle `ms_tick` pulse sets the debounce timebase. Configuration is written through a narrow register port:

- Address 0: bit 0 selects the polarity.
- Address 1: the low `NUM_CH` bits hold the inversion mask.
- Address 2+c: the debounce time of channel c, in milliseconds.

The outputs are one conditioned level per channel, plus one-clock rise and fall strobes taken from that final level.

Top module: `dinput_conditioner`

## Requirements
- R1: After reset, every `level_o` bit is 0 and no `rise_o` or `fall_o` bit is set. The polarity is active-high, the inversion mask is all zero, and every debounce time is 1 ms.
- R2: With polarity bit = 1 (active-high), a pin held at 1 is a closed contact, and once debounced it drives its `level_o` bit to 1.
- R3: With polarity bit = 0 (active-low), a pin held at 0 is a closed contact and debounces to `level_o` = 1, while a pin at 1 debounces to 0.
- R4: The debounced state only changes on a clock where `ms_tick` is 1. Clock cycles without a tick never move it.
- R5: A write to address 2+c sets channel c's debounce time without touching the other channels. A changed input moves the output on exactly the N-th tick it has held, where N is the programmed time.
- R6: If the polarity-corrected input returns to the debounced state before N ticks, the count restarts. A later change again needs a full N ticks.
- R7: A written debounce value of 0 acts as 1, and a value above 50 acts as 50.
- R8: Bit c of the inversion mask (address 1) flips channel c's output after debouncing. A mask write shows on `level_o` in the clock after the write, with no debounce delay.
- R9: `rise_o[c]` or `fall_o[c]` pulses for exactly one clock, in the cycle where `level_o[c]` goes 0→1 or 1→0. This includes changes caused by inversion writes.
- R10: Coming out of reset produces no edge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| pin_raw | input | NUM_CH | Raw input pin levels |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| level_o | output | NUM_CH | Conditioned logical level per channel |
| rise_o | output | NUM_CH | One-clock strobe on a 0→1 output change |
| fall_o | output | NUM_CH | One-clock strobe on a 1→0 output change |

## Verification
Pins are driven with:
- clean steps under each polarity;
- steps held for one tick fewer than the programmed time, and then for exactly that time, which exposes off-by-one errors in the tick count;
- a short bounce back to the old level partway through a count, which shows whether the count restarts or only pauses;
- long stretches of clocks without ticks, which separate tick-based counting from clock-based counting.

Channels with different debounce times are stepped together to show that each one is timed separately. Inversion writes made while the debounced state is steady show that the flip is immediate and that it still raises strobes.

// File: rtl/dic_pkg.sv
package dic_pkg;

   typedef enum logic {
      POL_ACT_LOW  = 1'b0,
      POL_ACT_HIGH = 1'b1
   } pol_e;

   // Restricts a requested debounce time to 1..hi.
   function automatic int clamp_ms(int req, int hi);
      if (req < 1)  return 1;
      if (req > hi) return hi;
      return req;
   endfunction

endpackage

// File: rtl/dic_sync.sv
module dic_sync #(
   parameter int NUM_CH = 5,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] d_in,
   output logic [NUM_CH-1:0] d_out
);

   if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_chain
      logic [NUM_CH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
         end else begin
            stg[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
         end
      end
      assign d_out = stg[STAGES-1];
   end

endmodule

// File: rtl/dic_cfg_regs.sv
module dic_cfg_regs
   import dic_pkg::*;
#(
   parameter int NUM_CH = 5,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3,
   parameter int MAX_MS = 50,
   parameter int TIME_W = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   output pol_e                          pol,
   output logic [NUM_CH-1:0]             inv_mask,
   output logic [NUM_CH-1:0][TIME_W-1:0] lim
);

   localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_INV = ADDR_W'(1);

   logic [TIME_W-1:0] wr_lim;
   assign wr_lim = TIME_W'(clamp_ms(int'(wdata), MAX_MS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol      <= POL_ACT_HIGH;
         inv_mask <= '0;
         for (int c = 0; c < NUM_CH; c++) lim[c] <= TIME_W'(1);
      end else if (wr) begin
         if (addr == A_POL) pol <= pol_e'(wdata[0]);
         if (addr == A_INV) inv_mask <= wdata[NUM_CH-1:0];
         for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(c + 2)) lim[c] <= wr_lim;
         end
      end
   end

endmodule

// File: rtl/dic_debounce.sv
module dic_debounce #(
   parameter int TIME_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              act_in,
   input  logic [TIME_W-1:0] lim,
   output logic              state
);

   logic [TIME_W-1:0] cnt;
   logic [TIME_W-1:0] cnt_nx;

   assign cnt_nx = cnt + TIME_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= 1'b0;
         cnt   <= '0;
      end else if (act_in == state) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt_nx >= lim) begin
            state <= act_in;
            cnt   <= '0;
         end else begin
            cnt <= cnt_nx;
         end
      end
   end

endmodule

// File: rtl/dic_edge.sv
module dic_edge #(
   parameter int NUM_CH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] lvl,
   output logic [NUM_CH-1:0] rise,
   output logic [NUM_CH-1:0] fall
);

   logic [NUM_CH-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/dinput_conditioner.sv
module dinput_conditioner
   import dic_pkg::*;
#(
   parameter int NUM_CH      = 5,
   parameter int MAX_MS      = 50,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = $clog2(NUM_CH + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic [NUM_CH-1:0] pin_raw,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [NUM_CH-1:0] level_o,
   output logic [NUM_CH-1:0] rise_o,
   output logic [NUM_CH-1:0] fall_o
);

   localparam int TIME_W = $clog2(MAX_MS + 1);

   if (NUM_CH < 1) begin : g_err_ch
      $error("NUM_CH must be at least 1");
   end
   if (MAX_MS < 1) begin : g_err_ms
      $error("MAX_MS must be at least 1");
   end
   if (DATA_W < NUM_CH || DATA_W < TIME_W) begin : g_err_dw
      $error("DATA_W too narrow for mask or time");
   end
   if ((1 << ADDR_W) < NUM_CH + 2) begin : g_err_aw
      $error("ADDR_W too narrow for register map");
   end
   if (SYNC_STAGES < 0) begin : g_err_sync
      $error("SYNC_STAGES must not be negative");
   end

   pol_e                          pol;
   logic [NUM_CH-1:0]             inv_mask;
   logic [NUM_CH-1:0][TIME_W-1:0] lim_w;
   logic [NUM_CH-1:0]             pin_s;
   logic [NUM_CH-1:0]             act;
   logic [NUM_CH-1:0]             deb_st;

   dic_cfg_regs #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .MAX_MS (MAX_MS),
      .TIME_W (TIME_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .pol      (pol),
      .inv_mask (inv_mask),
      .lim      (lim_w)
   );

   dic_sync #(
      .NUM_CH (NUM_CH),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_raw),
      .d_out (pin_s)
   );

   // Global polarity: result is 1 when the contact is closed.
   assign act = (pol == POL_ACT_HIGH) ? pin_s : ~pin_s;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dic_debounce #(
         .TIME_W (TIME_W)
      ) u_deb (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (ms_tick),
         .act_in (act[c]),
         .lim    (lim_w[c]),
         .state  (deb_st[c])
      );
   end

   assign level_o = deb_st ^ inv_mask;

   dic_edge #(
      .NUM_CH (NUM_CH)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (level_o),
      .rise  (rise_o),
      .fall  (fall_o)
   );

endmodule

// File: rtl/dic_checker.sv
module dic_checker #(
   parameter int NUM_CH = 5,
   parameter int MAX_MS = 50,
   parameter int TIME_W = 6
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          ms_tick,
   input logic [NUM_CH-1:0]             level_o,
   input logic [NUM_CH-1:0]             rise_o,
   input logic [NUM_CH-1:0]             fall_o,
   input logic [NUM_CH-1:0]             deb_st,
   input logic [NUM_CH-1:0][TIME_W-1:0] lim
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      AST_RISE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[c] |=> !rise_o[c]); // R9
      AST_FALL_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
         fall_o[c] |=> !fall_o[c]); // R9
      AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         !(rise_o[c] && fall_o[c])); // R9
      AST_RISE_ON_UP: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[c] |-> (level_o[c] && !$past(level_o[c]))); // R9
      AST_CHANGE_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
         (level_o[c] != $past(level_o[c])) |-> (rise_o[c] || fall_o[c])); // R9
      AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         (deb_st[c] != $past(deb_st[c])) |-> $past(ms_tick)); // R4
      AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (lim[c] >= TIME_W'(1)) && (lim[c] <= TIME_W'(MAX_MS))); // R7
   end

endmodule

bind dinput_conditioner dic_checker #(
   .NUM_CH (NUM_CH),
   .MAX_MS (MAX_MS),
   .TIME_W (TIME_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ms_tick (ms_tick),
   .level_o (level_o),
   .rise_o  (rise_o),
   .fall_o  (fall_o),
   .deb_st  (deb_st),
   .lim     (lim_w)
);

// File: tb/dinput_conditioner_test.sv
module dinput_conditioner_test;

   localparam int NCH = 5;
   localparam int AW  = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ms_tick = 1'b0;
   logic [NCH-1:0] pin_raw = '0;
   logic           cfg_wr = 1'b0;
   logic [AW-1:0]  cfg_addr = '0;
   logic [7:0]     cfg_wdata = '0;
   logic [NCH-1:0] level_o, rise_o, fall_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   dinput_conditioner uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ms_tick   (ms_tick),
      .pin_raw   (pin_raw),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .level_o   (level_o),
      .rise_o    (rise_o),
      .fall_o    (fall_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
   endtask

   task automatic wr_reg(input int a, input int d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = 8'(d);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // change pins, then let the synchronizer settle
   task automatic set_pins(input logic [NCH-1:0] v);
      @(negedge clk) pin_raw = v;
      clocks(3);
   endtask

   task automatic t_reset;
      chk("R1 level after reset", 32'(level_o), 0);
      chk("R10 rise after reset", 32'(rise_o), 0);
      chk("R10 fall after reset", 32'(fall_o), 0);
      ticks(3);
      chk("R1 idle stays low", 32'(level_o), 0);
      chk("R10 no strobe idle", 32'(rise_o | fall_o), 0);
   endtask

   task automatic t_active_high;
      set_pins(5'b00001);
      clocks(20);
      chk("R4 no change without tick", 32'(level_o), 0);
      ticks(1);
      chk("R2 default 1 ms debounce", 32'(level_o), 5'b00001);
      chk("R9 rise strobe", 32'(rise_o), 5'b00001);
      clocks(1);
      chk("R9 rise one clock", 32'(rise_o), 0);
      set_pins(5'b00000);
      ticks(1);
      chk("R2 release", 32'(level_o), 0);
      chk("R9 fall strobe", 32'(fall_o), 5'b00001);
      clocks(1);
      chk("R9 fall one clock", 32'(fall_o), 0);
   endtask

   task automatic t_per_channel;
      wr_reg(2 + 2, 5);
      set_pins(5'b01100);
      ticks(1);
      chk("R5 ch3 default time", 32'(level_o), 5'b01000);
      ticks(3);
      chk("R5 ch2 before 5th tick", 32'(level_o), 5'b01000);
      ticks(1);
      chk("R5 ch2 at 5th tick", 32'(level_o), 5'b01100);
      set_pins(5'b00000);
      ticks(5);
      chk("R5 both released", 32'(level_o), 0);
   endtask

   task automatic t_bounce;
      set_pins(5'b00100);
      ticks(3);
      set_pins(5'b00000);
      set_pins(5'b00100);
      ticks(4);
      chk("R6 count restarted", 32'(level_o), 0);
      ticks(1);
      chk("R6 full time after bounce", 32'(level_o), 5'b00100);
      set_pins(5'b00000);
      ticks(5);
      chk("R6 restore", 32'(level_o), 0);
   endtask

   task automatic t_clamp;
      wr_reg(2 + 1, 0);
      wr_reg(2 + 4, 200);
      set_pins(5'b10010);
      ticks(1);
      chk("R7 zero acts as 1", 32'(level_o), 5'b00010);
      ticks(48);
      chk("R7 large before 50", 32'(level_o), 5'b00010);
      ticks(1);
      chk("R7 large clamps to 50", 32'(level_o), 5'b10010);
      set_pins(5'b00000);
      ticks(50);
      chk("R7 restore", 32'(level_o), 0);
   endtask

   task automatic t_active_low;
      wr_reg(0, 0);
      ticks(50);
      chk("R3 low pins closed", 32'(level_o), 5'b11111);
      set_pins(5'b00001);
      ticks(1);
      chk("R3 high pin open", 32'(level_o), 5'b11110);
      set_pins(5'b00000);
      ticks(1);
      wr_reg(0, 1);
      ticks(50);
      chk("R2 back to active-high", 32'(level_o), 0);
   endtask

   task automatic t_invert;
      wr_reg(1, 5'b00101);
      chk("R8 inversion immediate", 32'(level_o), 5'b00101);
      chk("R9 rise from inversion", 32'(rise_o), 5'b00101);
      clocks(1);
      chk("R9 inversion strobe one clock", 32'(rise_o), 0);
      set_pins(5'b00001);
      ticks(1);
      chk("R8 closed contact deactivates", 32'(level_o), 5'b00100);
      chk("R9 fall on inverted channel", 32'(fall_o), 5'b00001);
      wr_reg(1, 0);
      chk("R8 mask cleared", 32'(level_o), 5'b00001);
      chk("R9 rise on uninvert", 32'(rise_o), 5'b00001);
      chk("R9 fall on uninvert", 32'(fall_o), 5'b00100);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      clocks(4);
      rst_n = 1'b1;
      clocks(2);
      t_reset();
      t_active_high();
      t_per_channel();
      t_bounce();
      t_clamp();
      t_active_low();
      t_invert();
      clocks(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule